// File: doc/BRIEF.md
# Sampled Angle and Rate Readout Port

This block sits between a tracking integrator and the pins of a converter. It watches two live words: a 12-bit unsigned absolute angle and a 12-bit two's-complement rate. A falling edge on an active-low sample strobe freezes both words into holding registers, so that a host reads a coherent pair no matter how long its reads take. A select line picks the angle (high) or the rate (low) holding register for output.

The selected word leaves through one 12-pin data bus. A mode line chooses between two uses of that bus. In parallel mode all twelve pins carry the word while both chip select and read are low. In serial mode the top pin becomes the serial data output and the pin below it becomes a serial clock input, modelled here as the separate input `sclk_i`. A falling read edge with chip select low starts a frame. The word then shifts out MSB first, one bit for each rising serial clock edge. Pad drivers are not in the block: each pin has its own output-enable bit and its own data bit.

Every control input, including the serial clock, passes through a two-flop synchroniser to the system clock, and edges are found on the synchronised copies. An input change therefore reaches the pins three system clock cycles later, and the serial clock must stay at each level for at least three system cycles. The data flow has no back-pressure. The host paces reads and frames through read, chip select and the serial clock, and the block never stalls. A sample strobe is taken whenever it arrives, even in the middle of a frame.

Top module: `readout_port`

## Requirements
- R1: After reset every output enable is 0, every data bit is 0, and both holding registers read 0.
- R2: A falling edge of `sample_n_i` copies `pos_live_i` and `vel_live_i` into the holding registers. Changes of the live words without that edge, and rising edges of the strobe, leave the values the port presents unchanged.
- R3: `sel_pos_i` = 1 presents the angle holding register and `sel_pos_i` = 0 presents the rate holding register, on either port.
- R4: In parallel mode (`par_mode_i` = 1), all twelve enables are 1 and `dbus_o` equals the selected word only while `cs_n_i` = 0 and `rd_n_i` = 0. Otherwise the enables and the data are all 0.
- R5: In serial mode (`par_mode_i` = 0), a falling edge of `rd_n_i` while `cs_n_i` = 0 starts a frame. Bit 11 of the selected word appears on `dbus_o[11]`, and each rising edge of `sclk_i` moves on to the next lower bit.
- R6: After the twelfth bit has been shifted out, `dbus_o[11]` reads 0 until the next frame starts.
- R7: In serial mode, while `cs_n_i` = 0 and `rd_n_i` = 0, only `dbus_oe_o[11]` is 1, and `dbus_o[10:0]` and `dbus_oe_o[10:0]` are 0.
- R8: A sample strobe during a serial frame does not change the bits of that frame. The next frame carries the new snapshot.
- R9: Rising serial clock edges while no frame is active (read high) shift nothing, so the next frame still starts with bit 11.
- R10: The rate word passes through without change to its sign: a rate of -2048 (0x800) reads as 0x800 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_live_i | input | 12 | Live absolute angle from the integrator, unsigned |
| vel_live_i | input | 12 | Live rate from the integrator, two's complement |
| sample_n_i | input | 1 | Sample strobe; a falling edge takes the snapshot |
| rd_n_i | input | 1 | Read, active low; output enable and serial frame start |
| cs_n_i | input | 1 | Chip select, active low |
| sel_pos_i | input | 1 | 1 selects the angle register, 0 the rate register |
| par_mode_i | input | 1 | 1 selects parallel mode, 0 serial mode |
| sclk_i | input | 1 | Serial clock, input path of pin 10 in serial mode |
| dbus_o | output | 12 | Data to the pads; serial data on bit 11 |
| dbus_oe_o | output | 12 | Output enable per pad |

## Verification
The snapshot is tried with three word pairs: asymmetric bit patterns, all-ones and zero values, and a rate with only its sign bit set. A swapped select, a bit-order error or a loss of sign extension would therefore show. Live words change without a strobe, and the read-back shows the old values, which separates edge capture from level capture. Serial frames run past twelve clocks to expose the zero fill. One frame takes a strobe halfway through, and a second frame follows it, so a shifter that reloads mid-frame is caught. Idle serial clocks before a frame and partial enables (only chip select low, or only read low) separate a gated enable from a free-running one.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int RDP_DEF_W      = 12;
  localparam int RDP_SYNC_DEPTH = 2;

  // control synchroniser lane positions
  localparam int CTL_SAMPLE = 0;
  localparam int CTL_RD     = 1;
  localparam int CTL_CS     = 2;
  localparam int CTL_SEL    = 3;
  localparam int CTL_MODE   = 4;
  localparam int CTL_SCLK   = 5;
  localparam int CTL_N      = 6;

  // idle levels: active-low strobes rest high
  localparam logic [CTL_N-1:0] CTL_IDLE = 6'b000111;

  typedef enum logic {
    PORT_SERIAL   = 1'b0,
    PORT_PARALLEL = 1'b1
  } port_mode_e;
endpackage

// File: rtl/rdp_sync.sv
module rdp_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] chain;
  logic [N-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d_i;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= chain[STAGES-1];
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rdp_snapshot.sv
module rdp_snapshot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] vel_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] vel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o <= '0;
      vel_o <= '0;
    end else if (take_i) begin
      pos_o <= pos_i;
      vel_o <= vel_i;
    end
  end
endmodule

// File: rtl/rdp_shifter.sv
module rdp_shifter #(
  parameter int W = 12,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  input  logic          shift_i,
  output logic [W-1:0]  bits_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      bits_o <= word_i;
      cnt_o  <= '0;
    end else if (shift_i && (cnt_o != LAST)) begin
      bits_o <= {bits_o[W-2:0], 1'b0};
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/readout_port.sv
module readout_port
  import rdp_pkg::*;
#(
  parameter int W = RDP_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos_live_i,
  input  logic [W-1:0] vel_live_i,
  input  logic         sample_n_i,
  input  logic         rd_n_i,
  input  logic         cs_n_i,
  input  logic         sel_pos_i,
  input  logic         par_mode_i,
  input  logic         sclk_i,
  output logic [W-1:0] dbus_o,
  output logic [W-1:0] dbus_oe_o
);
  localparam int CW = $clog2(W + 1);

  logic [CTL_N-1:0] ctl_raw, ctl_q, ctl_rise, ctl_fall;
  logic [W-1:0]     pos_hold, vel_hold, sel_word, shreg;
  logic [CW-1:0]    bit_cnt;
  logic             cs_q, rd_q, mode_q, take, load, shift, frame_active, enabled;
  port_mode_e       port_mode;

  assign ctl_raw[CTL_SAMPLE] = sample_n_i;
  assign ctl_raw[CTL_RD]     = rd_n_i;
  assign ctl_raw[CTL_CS]     = cs_n_i;
  assign ctl_raw[CTL_SEL]    = sel_pos_i;
  assign ctl_raw[CTL_MODE]   = par_mode_i;
  assign ctl_raw[CTL_SCLK]   = sclk_i;

  rdp_sync #(.N(CTL_N), .STAGES(RDP_SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw),
    .q_o(ctl_q), .rise_o(ctl_rise), .fall_o(ctl_fall)
  );

  assign cs_q      = ctl_q[CTL_CS];
  assign rd_q      = ctl_q[CTL_RD];
  assign mode_q    = ctl_q[CTL_MODE];
  assign port_mode = port_mode_e'(mode_q);
  assign take      = ctl_fall[CTL_SAMPLE];
  assign enabled   = !cs_q && !rd_q;

  rdp_snapshot #(.W(W)) u_snap (
    .clk(clk), .rst_n(rst_n), .take_i(take),
    .pos_i(pos_live_i), .vel_i(vel_live_i),
    .pos_o(pos_hold), .vel_o(vel_hold)
  );

  assign sel_word = ctl_q[CTL_SEL] ? pos_hold : vel_hold;

  // frame starts on a synchronised read fall with chip select low in serial mode
  assign load  = ctl_fall[CTL_RD] && !cs_q && (port_mode == PORT_SERIAL);
  assign shift = ctl_rise[CTL_SCLK] && frame_active && enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        frame_active <= 1'b0;
    else if (load)                                     frame_active <= 1'b1;
    else if (!enabled || port_mode != PORT_SERIAL)     frame_active <= 1'b0;
  end

  rdp_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(sel_word),
    .shift_i(shift), .bits_o(shreg), .cnt_o(bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbus_o    <= '0;
      dbus_oe_o <= '0;
    end else if (enabled && port_mode == PORT_PARALLEL) begin
      dbus_o    <= sel_word;
      dbus_oe_o <= '1;
    end else if (enabled) begin
      dbus_o    <= {shreg[W-1] & frame_active, {(W-1){1'b0}}};
      dbus_oe_o <= {1'b1, {(W-1){1'b0}}};
    end else begin
      dbus_o    <= '0;
      dbus_oe_o <= '0;
    end
  end
endmodule

// File: rtl/readout_port_chk.sv
module readout_port_chk #(
  parameter int W = 12,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_q,
  input logic          rd_q,
  input logic          mode_q,
  input logic          take,
  input logic          load,
  input logic          shift,
  input logic [W-1:0]  pos_hold,
  input logic [W-1:0]  vel_hold,
  input logic [W-1:0]  shreg,
  input logic [CW-1:0] bit_cnt,
  input logic [W-1:0]  dbus_o,
  input logic [W-1:0]  dbus_oe_o
);
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(pos_hold) && $stable(vel_hold)));

  assert_enable_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe_o != '0) |-> $past(!cs_q && !rd_q));

  assert_idle_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe_o == '0) |-> (dbus_o == '0));

  assert_low_pins_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe_o[W-2:0] != '0) |-> $past(mode_q));

  assert_enable_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe_o == '0) || (dbus_oe_o == '1) || (dbus_oe_o == {1'b1, {(W-1){1'b0}}}));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(W));

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CW'(W)) |-> (shreg == '0));

  assert_frame_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(shreg));
endmodule

bind readout_port readout_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .rd_q(rd_q), .mode_q(mode_q),
  .take(take), .load(load), .shift(shift), .pos_hold(pos_hold),
  .vel_hold(vel_hold), .shreg(shreg), .bit_cnt(bit_cnt),
  .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o)
);

// File: tb/sim_readout_port.sv
module sim_readout_port;
  localparam int W = 12;
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  typedef struct {
    logic [W-1:0] d;
    logic [W-1:0] oe;
    string        tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] pos_live = '0, vel_live = '0;
  logic sample_n = 1, rd_n = 1, cs_n = 1, sel_pos = 0, par_mode = 0, sclk = 0;
  logic [W-1:0] dbus, dbus_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  readout_port #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pos_live_i(pos_live), .vel_live_i(vel_live),
    .sample_n_i(sample_n), .rd_n_i(rd_n), .cs_n_i(cs_n), .sel_pos_i(sel_pos),
    .par_mode_i(par_mode), .sclk_i(sclk), .dbus_o(dbus), .dbus_oe_o(dbus_oe)
  );

  // monitor: compares queued expectations against the pins
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (dbus !== e.d || dbus_oe !== e.oe) begin
          failures++;
          $display("FAIL %s: data=%h oe=%h expected data=%h oe=%h",
                   e.tag, dbus, dbus_oe, e.d, e.oe);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    step(5);
  endtask

  task automatic expect_pins(input logic [W-1:0] d, input logic [W-1:0] oe, input string tag);
    exp_t e;
    e.d = d; e.oe = oe; e.tag = tag;
    sb.push_back(e);
    step(2);
  endtask

  task automatic do_sample(input logic [W-1:0] p, input logic [W-1:0] v);
    pos_live = p; vel_live = v;
    settle();
    sample_n = 0; settle();
    sample_n = 1; settle();
  endtask

  task automatic par_read(input logic sel, input logic [W-1:0] expd, input string tag);
    par_mode = 1; sel_pos = sel; settle();
    cs_n = 0; rd_n = 0; settle();
    expect_pins(expd, '1, tag);
    rd_n = 1; cs_n = 1; settle();
    expect_pins('0, '0, tag);
  endtask

  task automatic ser_frame(input logic sel, input logic [W-1:0] word, input int extra,
                           input int mid_idx, input logic [W-1:0] np,
                           input logic [W-1:0] nv, input string tag);
    par_mode = 0; sel_pos = sel; cs_n = 0; settle();
    rd_n = 0; settle();
    for (int i = 0; i < W + extra; i++) begin
      logic b;
      b = (i < W) ? word[W-1-i] : 1'b0;
      if (i == mid_idx) do_sample(np, nv);
      expect_pins({b, {(W-1){1'b0}}}, TOP_ONLY, tag);
      sclk = 1; settle();
      sclk = 0; settle();
    end
    rd_n = 1; cs_n = 1; settle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: data=%h oe=%h expected run completion", dbus, dbus_oe);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_pins('0, '0, "R1 reset pins");
    rst_n = 1; settle();
    expect_pins('0, '0, "R1 idle after reset");
    par_read(1, 12'h000, "R1 angle reg after reset");
    par_read(0, 12'h000, "R1 rate reg after reset");

    do_sample(12'hA5C, 12'h3F1);
    par_read(1, 12'hA5C, "R2 R3 angle snapshot");
    par_read(0, 12'h3F1, "R3 rate snapshot");

    pos_live = 12'h111; vel_live = 12'h222; settle();
    par_read(1, 12'hA5C, "R2 live change ignored");

    par_mode = 1; cs_n = 1; rd_n = 0; settle();
    expect_pins('0, '0, "R4 read low, chip select high");
    rd_n = 1; cs_n = 0; settle();
    expect_pins('0, '0, "R4 chip select low, read high");
    cs_n = 1; settle();

    ser_frame(1, 12'hA5C, 3, -1, '0, '0, "R5 R6 R7 serial angle");
    ser_frame(0, 12'h3F1, 1, -1, '0, '0, "R3 R5 serial rate");

    do_sample(12'hFFF, 12'h800);
    par_read(0, 12'h800, "R10 negative rate parallel");
    ser_frame(0, 12'h800, 1, -1, '0, '0, "R10 negative rate serial");
    par_read(1, 12'hFFF, "R3 all ones angle");

    ser_frame(1, 12'hFFF, 0, 4, 12'h6B2, 12'h04D, "R8 strobe mid frame");
    ser_frame(1, 12'h6B2, 0, -1, '0, '0, "R8 new snapshot next frame");

    par_mode = 0; cs_n = 0; settle();
    for (int k = 0; k < 3; k++) begin
      sclk = 1; settle(); sclk = 0; settle();
    end
    expect_pins('0, '0, "R9 idle serial clocks");
    cs_n = 1; settle();
    ser_frame(0, 12'h04D, 0, -1, '0, '0, "R9 frame starts at MSB");

    done = 1;
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule